// File: doc/BRIEF.md
# DMA Controller-Level Register Unit

This block holds the controller-wide state of a four-channel DMA engine: the command word, the status byte with its request and terminal-count halves, the per-channel mask, and one mode byte for each channel. Software reaches it over a narrow byte-wide register bus with eight register selects. The transfer side of the engine reports terminal counts and may hold or release channel requests through per-channel pulse inputs. The block works out which channels may be serviced right now and hands the transfer engine each channel's mode.

The unit also emits two one-cycle pulses. One tells the address/count register file to clear its byte-pointer toggle. The other tells it that a master reset was written. Address and count registers and the data movement itself live elsewhere.

Top module: `dmac_regs`

## Requirements
- R1: After rst_n is low, every mask bit is 1, the status byte is 0, the command disable bit is 0, all mode bytes are 0 and service_ok is 0.
- R2: A write to select 0 loads the command only if the data is 0x00 or 0x04. Any other value leaves the command unchanged. ctrl_disable shows command bit 2.
- R3: A write to select 1 picks a channel with data[1:0]. It sets status request bit 4+ch when data[2] is 1 and clears it when data[2] is 0. It always clears terminal-count bit ch.
- R4: A write to select 2 picks a channel with data[1:0]. It sets that channel's mask bit when data[2] is 1 and clears it when data[2] is 0.
- R5: A write to select 3 stores the whole data byte as the mode of channel data[1:0], visible on chan_mode[8*ch+7:8*ch]. Other channels' modes keep their values.
- R6: A write to select 4 raises ff_clear for exactly one cycle, starting one clock after the write.
- R7: A write to select 5 sets every mask bit, zeroes status and command, and raises both ff_clear and mst_reset for one cycle, starting one clock after the write.
- R8: A write to select 6 clears all mask bits. A write to select 7 loads mask bit n from data[n].
- R9: With bus_rd high, select 0 returns the status byte and select 7 returns the mask in bits [3:0]. Every other select returns 0. A status read clears status bits [3:0] on the following clock and leaves bits [7:4] unchanged.
- R10: service_ok[n] is 1 exactly when mask bit n is 0 and status request bit 4+n is 1.
- R11: hold_req[n] sets status bit 4+n. rel_req[n] clears it, and wins when both are high in the same cycle. tc_hit[n] sets status bit n.
- R12: A register-bus write to select 1 or 5 takes priority over hold, release and terminal-count pulses to the same status bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 3 | Register select 0..7 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| hold_req | input | 4 | Per-channel request hold pulse |
| rel_req | input | 4 | Per-channel request release pulse |
| tc_hit | input | 4 | Per-channel terminal-count pulse |
| chan_mode | output | 32 | Mode bytes, channel n in bits [8n+7:8n] |
| ctrl_disable | output | 1 | Controller disable bit of the command |
| ff_clear | output | 1 | Byte-pointer toggle clear pulse |
| mst_reset | output | 1 | Master reset pulse |
| service_ok | output | 4 | Channels eligible for service |

## Verification
The properties assume that bus_wr and bus_rd are never high in the same cycle. The bench issues each register access alone, so this assumption holds. The hold-to-status property is only claimed in cycles with no bus write to select 1 or 5 and no release on the same channel, so cycles where the bus wins are not covered by it. The bench applies pulses both alone and deliberately in the same cycle as a conflicting request write, to reach the priority rule through the status read port.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned NCH  = 4;
  localparam int unsigned CHW  = 2;
  localparam int unsigned BYTE = 8;

  typedef enum logic [2:0] {
    SEL_CMD_STAT = 3'd0,
    SEL_SWREQ    = 3'd1,
    SEL_MASK1    = 3'd2,
    SEL_MODE     = 3'd3,
    SEL_FFCLR    = 3'd4,
    SEL_MRST     = 3'd5,
    SEL_MASKCLR  = 3'd6,
    SEL_MASKALL  = 3'd7
  } reg_sel_e;

  localparam logic [7:0] CMD_ALLOWED = 8'h04;
endpackage

// File: rtl/dmac_status_reg.sv
module dmac_status_reg
  import dmac_pkg::*;
#(
  parameter int unsigned N  = NCH,
  parameter int unsigned CW = CHW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    hold_req,
  input  logic [N-1:0]    rel_req,
  input  logic [N-1:0]    tc_hit,
  input  logic            sw_we,
  input  logic [CW-1:0]   sw_ch,
  input  logic            sw_set,
  input  logic            rd_clear,
  input  logic            clr_all,
  output logic [2*N-1:0]  status_q
);
  logic [2*N-1:0] nxt;

  always_comb begin
    nxt = status_q;
    nxt[2*N-1:N] = (nxt[2*N-1:N] | hold_req) & ~rel_req;
    nxt[N-1:0]   = nxt[N-1:0] | tc_hit;
    if (rd_clear) nxt[N-1:0] = '0;
    if (sw_we) begin
      nxt[N + 32'(sw_ch)] = sw_set;
      nxt[sw_ch]          = 1'b0;
    end
    if (clr_all) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt;
  end
endmodule

// File: rtl/dmac_mask_reg.sv
module dmac_mask_reg
  import dmac_pkg::*;
#(
  parameter int unsigned N  = NCH,
  parameter int unsigned CW = CHW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          one_we,
  input  logic [CW-1:0] one_ch,
  input  logic          one_set,
  input  logic          all_clr,
  input  logic          all_set,
  input  logic          all_we,
  input  logic [N-1:0]  all_data,
  output logic [N-1:0]  mask_q
);
  logic [N-1:0] nxt;

  always_comb begin
    nxt = mask_q;
    if (one_we)  nxt[one_ch] = one_set;
    if (all_clr) nxt = '0;
    if (all_we)  nxt = all_data;
    if (all_set) nxt = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= nxt;
  end
endmodule

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank
  import dmac_pkg::*;
#(
  parameter int unsigned N  = NCH,
  parameter int unsigned CW = CHW,
  parameter int unsigned W  = BYTE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] modes
);
  for (genvar g = 0; g < N; g++) begin : g_chan
    logic [W-1:0] mode_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else if (we && (wdata[CW-1:0] == CW'(g))) mode_q <= wdata;
    end
    assign modes[g*W +: W] = mode_q;
  end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int unsigned N  = NCH,
  parameter int unsigned CW = CHW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [2:0]     bus_sel,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic [N-1:0]   hold_req,
  input  logic [N-1:0]   rel_req,
  input  logic [N-1:0]   tc_hit,
  output logic [N*8-1:0] chan_mode,
  output logic           ctrl_disable,
  output logic           ff_clear,
  output logic           mst_reset,
  output logic [N-1:0]   service_ok
);
  localparam int unsigned SW = 2 * N;

  reg_sel_e     sel;
  logic         wr_stat, wr_req, wr_msk1, wr_mode, wr_ffc, wr_mrst, wr_mclr, wr_mall;
  logic [7:0]   cmd_q;
  logic [SW-1:0] status_q;
  logic [N-1:0] mask_q;
  logic         ffc_q, mrst_q;

  assign sel     = reg_sel_e'(bus_sel);
  assign wr_stat = bus_wr && sel == SEL_CMD_STAT;
  assign wr_req  = bus_wr && sel == SEL_SWREQ;
  assign wr_msk1 = bus_wr && sel == SEL_MASK1;
  assign wr_mode = bus_wr && sel == SEL_MODE;
  assign wr_ffc  = bus_wr && sel == SEL_FFCLR;
  assign wr_mrst = bus_wr && sel == SEL_MRST;
  assign wr_mclr = bus_wr && sel == SEL_MASKCLR;
  assign wr_mall = bus_wr && sel == SEL_MASKALL;

  // command: accept zero or the disable bit alone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmd_q <= '0;
    else if (wr_mrst) cmd_q <= '0;
    else if (wr_stat && ((bus_wdata & ~CMD_ALLOWED) == 8'h00)) cmd_q <= bus_wdata;
  end
  assign ctrl_disable = cmd_q[2];

  // registered strobes toward the address/count register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ffc_q  <= 1'b0;
      mrst_q <= 1'b0;
    end else begin
      ffc_q  <= wr_ffc | wr_mrst;
      mrst_q <= wr_mrst;
    end
  end
  assign ff_clear  = ffc_q;
  assign mst_reset = mrst_q;

  dmac_status_reg #(.N(N), .CW(CW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .rel_req  (rel_req),
    .tc_hit   (tc_hit),
    .sw_we    (wr_req),
    .sw_ch    (bus_wdata[CW-1:0]),
    .sw_set   (bus_wdata[2]),
    .rd_clear (bus_rd && sel == SEL_CMD_STAT),
    .clr_all  (wr_mrst),
    .status_q (status_q)
  );

  dmac_mask_reg #(.N(N), .CW(CW)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .one_we   (wr_msk1),
    .one_ch   (bus_wdata[CW-1:0]),
    .one_set  (bus_wdata[2]),
    .all_clr  (wr_mclr),
    .all_set  (wr_mrst),
    .all_we   (wr_mall),
    .all_data (bus_wdata[N-1:0]),
    .mask_q   (mask_q)
  );

  dmac_mode_bank #(.N(N), .CW(CW), .W(8)) u_modes (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_mode),
    .wdata (bus_wdata),
    .modes (chan_mode)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_CMD_STAT: bus_rdata = status_q;
        SEL_MASKALL:  bus_rdata = 8'(mask_q);
        default:      bus_rdata = '0;
      endcase
    end
  end

  assign service_ok = ~mask_q & status_q[SW-1:N];
endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk #(
  parameter int unsigned N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [2:0]     bus_sel,
  input logic [7:0]     bus_wdata,
  input logic [N-1:0]   hold_req,
  input logic [N-1:0]   rel_req,
  input logic           ctrl_disable,
  input logic           ff_clear,
  input logic           mst_reset,
  input logic [N-1:0]   service_ok,
  input logic [2*N-1:0] status_q
);
  AST_BAD_CMD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 3'd0 && bus_wdata != 8'h00 && bus_wdata != 8'h04)
    |=> $stable(ctrl_disable)); // R2

  AST_MASK_ONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 3'd2 && bus_wdata[2])
    |=> service_ok[bus_wdata[1:0]] == 1'b0); // R4

  AST_FFCLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clear |=> !ff_clear || $past(bus_wr && (bus_sel == 3'd4 || bus_sel == 3'd5))); // R6

  AST_MRST_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 3'd5)
    |=> (mst_reset && ff_clear && service_ok == '0 && !ctrl_disable && status_q == '0)); // R7

  AST_STAT_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == 3'd0) |=> status_q[N-1:0] == '0); // R9

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R9

  for (genvar g = 0; g < N; g++) begin : g_ch
    AST_HOLD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_req[g] && !rel_req[g] && !(bus_wr && (bus_sel == 3'd1 || bus_sel == 3'd5)))
      |=> status_q[N+g]); // R11
    AST_REL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_req[g] && !(bus_wr && (bus_sel == 3'd1 || bus_sel == 3'd5)))
      |=> !status_q[N+g]); // R11
  end
endmodule

bind dmac_regs dmac_regs_chk #(.N(N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_sel      (bus_sel),
  .bus_wdata    (bus_wdata),
  .hold_req     (hold_req),
  .rel_req      (rel_req),
  .ctrl_disable (ctrl_disable),
  .ff_clear     (ff_clear),
  .mst_reset    (mst_reset),
  .service_ok   (service_ok),
  .status_q     (status_q)
);

// File: tb/test_dmac_regs.sv
`timescale 1ns/1ps
module test_dmac_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  hold_req = '0, rel_req = '0, tc_hit = '0;
  logic [31:0] chan_mode;
  logic        ctrl_disable, ff_clear, mst_reset;
  logic [3:0]  service_ok;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmac_regs i_dmac_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hold_req(hold_req), .rel_req(rel_req), .tc_hit(tc_hit),
    .chan_mode(chan_mode), .ctrl_disable(ctrl_disable), .ff_clear(ff_clear),
    .mst_reset(mst_reset), .service_ok(service_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_sel = s; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] h, input logic [3:0] r, input logic [3:0] t);
    @(negedge clk); hold_req = h; rel_req = r; tc_hit = t;
    @(negedge clk); hold_req = '0; rel_req = '0; tc_hit = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 service_ok", 32'(service_ok), 0);
    check("R1 disable", 32'(ctrl_disable), 0);
    check("R1 modes", chan_mode, 0);
    rd(3'd7, v); check("R1 mask", 32'(v), 32'h0f);
    rd(3'd0, v); check("R1 status", 32'(v), 0);
  endtask

  task automatic t_command();
    wr(3'd0, 8'h04); check("R2 accept 04", 32'(ctrl_disable), 1);
    wr(3'd0, 8'h84); check("R2 reject 84", 32'(ctrl_disable), 1);
    wr(3'd0, 8'h00); check("R2 accept 00", 32'(ctrl_disable), 0);
    wr(3'd0, 8'h05); check("R2 reject 05", 32'(ctrl_disable), 0);
  endtask

  task automatic t_request_elig();
    logic [7:0] v;
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h06);
    check("R10 masked", 32'(service_ok), 0);
    wr(3'd6, 8'h00);
    check("R8 R10 after clear-all", 32'(service_ok), 32'h4);
    pulse(4'h0, 4'h0, 4'h4);
    wr(3'd1, 8'h02);
    rd(3'd0, v); check("R3 clear req and tc", 32'(v), 0);
    check("R3 elig gone", 32'(service_ok), 0);
  endtask

  task automatic t_mask();
    wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    wr(3'd1, 8'h05); wr(3'd1, 8'h07);
    check("R10 ch1 ch3", 32'(service_ok), 32'ha);
    wr(3'd2, 8'h07); check("R4 set mask3", 32'(service_ok), 32'h2);
    wr(3'd2, 8'h03); check("R4 clear mask3", 32'(service_ok), 32'ha);
    wr(3'd7, 8'h02); check("R8 load mask", 32'(service_ok), 32'h8);
  endtask

  task automatic t_mode();
    wr(3'd3, 8'h96);
    check("R5 ch2 mode", chan_mode, 32'h0096_0000);
    wr(3'd3, 8'h5b);
    check("R5 ch3 mode", chan_mode, 32'h5b96_0000);
  endtask

  task automatic t_pulses();
    logic [7:0] v;
    check("R6 idle", 32'(ff_clear), 0);
    wr(3'd4, 8'h00);
    check("R6 ff pulse", 32'({ff_clear, mst_reset}), 32'h2);
    @(negedge clk); check("R6 ff drop", 32'(ff_clear), 0);
    wr(3'd0, 8'h04); wr(3'd6, 8'h00); wr(3'd1, 8'h04);
    wr(3'd5, 8'h00);
    check("R7 pulses", 32'({ff_clear, mst_reset}), 32'h3);
    check("R7 disable", 32'(ctrl_disable), 0);
    @(negedge clk); check("R7 drop", 32'({ff_clear, mst_reset}), 0);
    rd(3'd7, v); check("R7 mask", 32'(v), 32'h0f);
    rd(3'd0, v); check("R7 status", 32'(v), 0);
  endtask

  task automatic t_status_read();
    logic [7:0] v;
    wr(3'd5, 8'h00);
    pulse(4'h9, 4'h0, 4'h5);
    rd(3'd0, v); check("R9 R11 status", 32'(v), 32'h95);
    rd(3'd0, v); check("R9 low cleared", 32'(v), 32'h90);
    rd(3'd3, v); check("R9 other sel", 32'(v), 0);
    pulse(4'h1, 4'h8, 4'h0);
    rd(3'd0, v); check("R11 release", 32'(v), 32'h10);
    pulse(4'h2, 4'h2, 4'h0);
    rd(3'd0, v); check("R11 release wins", 32'(v), 32'h10);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    wr(3'd5, 8'h00);
    @(negedge clk); hold_req = 4'h2; tc_hit = 4'h2; bus_wr = 1'b1; bus_sel = 3'd1; bus_wdata = 8'h01;
    @(negedge clk); hold_req = '0; tc_hit = '0; bus_wr = 1'b0;
    rd(3'd0, v); check("R12 bus over hold", 32'(v), 0);
    @(negedge clk); rel_req = 4'h1; bus_wr = 1'b1; bus_sel = 3'd1; bus_wdata = 8'h04;
    @(negedge clk); rel_req = '0; bus_wr = 1'b0;
    rd(3'd0, v); check("R12 bus over release", 32'(v), 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_command();
    t_request_elig();
    t_mask();
    t_mode();
    t_pulses();
    t_status_read();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule